// File: doc/BRIEF.md
# Protected Power-of-Two Clock-Enable Divider

This block slows down every synchronous consumer of a chip region by one common factor. It runs entirely on the fast, undivided clock. It produces a single-cycle enable strobe, `clk_en`, once per divided period. The CPU, I/O, converter and memory logic all qualify their registers with that strobe, so they all see the same division. A 4-bit select code picks division by 2 to the power of the code, for codes 0 to 8, which covers divide-by-1 up to divide-by-256.

The select code sits behind an arming step, so stray software writes cannot change the clock rate. Software first writes the exact arming pattern, which is the arm flag alone. It then has a short window in which to write the new code with the arm flag cleared. The new division is applied only when a divided period ends. The first period at the new rate is always complete, so no strobe spacing during a change is shorter than both the old and the new period.

A synchronous active-high reset loads a parameterised default code: divide-by-1, or divide-by-8 when `DEF_DIV8` is set. The control byte can be read back at any time.

Top module: `clkdiv_guarded`

## Requirements
- R1: While `rst` is high and in the first cycle after it falls, `rd_data` reads 0x00 (default code 0, arm flag clear), and `clk_en` is high in that first cycle.
- R2: With active code c (0..8), `clk_en` is high for exactly one cycle every 2^c cycles.
- R3: The arm flag (bit 7) sets only after a write of exactly 0x80. Writing 0x81 or any other value leaves it clear.
- R4: After the arming write is sampled in cycle u, a select write is accepted in cycles u+1 through u+4. Bit 7 must be 0 in that write, and the code sits in bits 3:0. If no write arrives by then, the arm flag reads 0 from cycle u+5, and a later select write is ignored.
- R5: A select write made while the block is not armed leaves the code unchanged.
- R6: Codes 9 to 15 written in an armed select write are ignored. The code stays as it was and the arm flag clears.
- R7: While armed, a write with bit 7 set that is not exactly 0x80 changes no code and clears the arm flag.
- R8: `rd_data` is {arm flag, 3'b000, select code}. The code read back is the most recently accepted one.
- R9: A new code takes effect at the end of the divided period in progress. From then on each strobe gap equals the new period; no gap is cut short.
- R10: An accepted select write clears the arm flag in the following cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Undivided clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Write strobe for the control byte |
| wr_data | input | 8 | Control byte to write |
| rd_data | output | 8 | Control byte read-back |
| clk_en | output | 1 | One-cycle strobe per divided period |

## Verification
Every cycle, the assertions check four things:
- The stored code changes only in the cycle after an armed write.
- The stored code never holds a reserved value.
- The arm flag rises only after the exact arming pattern, and an armed select write clears it.
- The active division switches only on a strobe, and the counter is reloaded to a full period.

The exact strobe spacing across a rate change needs the bench's scoreboard, which measures the gaps between strobes. So do the window edge at the fourth cycle and the rejection of late, unarmed, reserved or malformed writes, which show only in the read-back and the rate that follows.

// File: rtl/clkdiv_pkg.sv
package clkdiv_pkg;
    localparam int SEL_W    = 4;
    localparam int MAX_CODE = 8;
    localparam int CNT_W    = MAX_CODE;
    localparam int WIN_CYC  = 4;
    localparam int WIN_W    = $clog2(WIN_CYC);

    typedef logic [SEL_W-1:0] sel_t;
    typedef logic [CNT_W-1:0] cnt_t;

    typedef struct packed {
        logic       arm;
        logic [2:0] spare;
        sel_t       code;
    } ctrl_byte_t;

    localparam ctrl_byte_t ARM_PATTERN = '{arm: 1'b1, spare: 3'b000, code: '0};

    function automatic logic code_ok(sel_t c);
        return c <= sel_t'(MAX_CODE);
    endfunction

    function automatic cnt_t reload_of(sel_t c);
        logic [CNT_W:0] v;
        v = ((CNT_W+1)'(1) << c) - (CNT_W+1)'(1);
        return v[CNT_W-1:0];
    endfunction
endpackage

// File: rtl/clkdiv_guard.sv
module clkdiv_guard
    import clkdiv_pkg::*;
#(
    parameter sel_t DEF_CODE = '0
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       wr_en,
    input  ctrl_byte_t wr_byte,
    output sel_t       code_q,
    output logic       armed_q
);
    logic [WIN_W-1:0] win_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            code_q  <= DEF_CODE;
            armed_q <= 1'b0;
            win_q   <= '0;
        end else if (wr_en) begin
            if (wr_byte == ARM_PATTERN) begin
                armed_q <= 1'b1;
                win_q   <= WIN_W'(WIN_CYC - 1);
            end else begin
                armed_q <= 1'b0;
                win_q   <= '0;
                if (armed_q && !wr_byte.arm && code_ok(wr_byte.code))
                    code_q <= wr_byte.code;
            end
        end else if (armed_q) begin
            if (win_q == '0)
                armed_q <= 1'b0;
            else
                win_q <= win_q - 1'b1;
        end
    end

    // R5
    code_guard_chk: assert property (@(posedge clk) disable iff (rst)
        !$stable(code_q) |-> $past(armed_q && wr_en && !wr_byte.arm));

    // R6
    code_range_chk: assert property (@(posedge clk) disable iff (rst)
        code_ok(code_q));

    // R3
    arm_source_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(armed_q) |-> $past(wr_en && wr_byte == ARM_PATTERN));

    // R10
    arm_consume_chk: assert property (@(posedge clk) disable iff (rst)
        armed_q && wr_en && !wr_byte.arm |=> !armed_q);
endmodule

// File: rtl/clkdiv_counter.sv
module clkdiv_counter
    import clkdiv_pkg::*;
#(
    parameter sel_t DEF_CODE = '0
) (
    input  logic clk,
    input  logic rst,
    input  sel_t req_code,
    output logic tick
);
    cnt_t cnt_q;
    sel_t cur_q;

    assign tick = (cnt_q == '0);

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
            cur_q <= DEF_CODE;
        end else if (tick) begin
            cur_q <= req_code;
            cnt_q <= reload_of(req_code);
        end else begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    // R9
    switch_on_tick_chk: assert property (@(posedge clk) disable iff (rst)
        !$stable(cur_q) |-> $past(tick));

    // R9
    full_period_chk: assert property (@(posedge clk) disable iff (rst)
        $past(tick) |-> cnt_q == reload_of(cur_q));

    // R2
    cnt_bound_chk: assert property (@(posedge clk) disable iff (rst)
        cnt_q <= reload_of(cur_q));
endmodule

// File: rtl/clkdiv_guarded.sv
module clkdiv_guarded
    import clkdiv_pkg::*;
#(
    parameter bit DEF_DIV8 = 1'b0
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       wr_en,
    input  logic [7:0] wr_data,
    output logic [7:0] rd_data,
    output logic       clk_en
);
    localparam sel_t DEF_CODE = DEF_DIV8 ? sel_t'(3) : sel_t'(0);

    sel_t       code_q;
    logic       armed_q;
    ctrl_byte_t rd_byte;

    clkdiv_guard #(.DEF_CODE(DEF_CODE)) u_guard (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (wr_en),
        .wr_byte (ctrl_byte_t'(wr_data)),
        .code_q  (code_q),
        .armed_q (armed_q)
    );

    clkdiv_counter #(.DEF_CODE(DEF_CODE)) u_counter (
        .clk      (clk),
        .rst      (rst),
        .req_code (code_q),
        .tick     (clk_en)
    );

    always_comb begin
        rd_byte       = '0;
        rd_byte.arm   = armed_q;
        rd_byte.code  = code_q;
    end
    assign rd_data = rd_byte;
endmodule

// File: tb/clkdiv_guarded_bench.sv
`timescale 1ns/1ps
module clkdiv_guarded_bench;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       wr_en = 1'b0;
    logic [7:0] wr_data = 8'h00;
    logic [7:0] rd_data;
    logic       clk_en;

    int checks = 0;
    int fails  = 0;
    int exp_q[$];
    int cyc = 0;
    int last_tick = 0;
    bit seen = 0;
    int model_code = 0;

    always #2 clk = ~clk;

    clkdiv_guarded u_clkdiv_guarded (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_data(wr_data),
        .rd_data(rd_data), .clk_en(clk_en)
    );

    task automatic check(int got, int exp, string req);
        checks++;
        if (got != exp) begin
            fails++;
            $display("FAIL %s: got %0h expected %0h", req, got, exp);
        end
    endtask

    // monitor: measure strobe gaps and pop expected ones
    always @(negedge clk) begin
        if (!rst) begin
            cyc++;
            if (clk_en) begin
                if (seen && exp_q.size() > 0)
                    check(cyc - last_tick, exp_q.pop_front(), "R2/R9 gap");
                seen = 1;
                last_tick = cyc;
            end
        end
    end

    task automatic wr_byte(logic [7:0] d);
        wr_en = 1'b1; wr_data = d;
        @(negedge clk); #1;
        wr_en = 1'b0; wr_data = 8'h00;
    endtask

    task automatic idle(int n);
        repeat (n) @(negedge clk);
        #1;
    endtask

    task automatic wait_tick();
        do @(negedge clk); while (!clk_en);
        #1;
    endtask

    task automatic settle();
        while (exp_q.size() != 0) @(negedge clk);
        wait_tick();
        wait_tick();
    endtask

    task automatic expect_steady(int n, int k);
        settle();
        wait_tick();
        repeat (k) exp_q.push_back(n);
    endtask

    task automatic switch_to(int code);
        settle();
        wait_tick();
        if (model_code == 0) begin
            exp_q.push_back(1); exp_q.push_back(1);
        end else begin
            exp_q.push_back(1 << model_code);
        end
        wr_byte(8'h80);
        wr_byte(8'(code));
        repeat (2) exp_q.push_back(1 << code);
        model_code = code;
        check(rd_data, code, "R8/R10 readback after switch");
    endtask

    initial begin
        idle(1);
        check(rd_data, 8'h00, "R1 rd during reset");
        idle(2);
        rst = 1'b0;
        @(negedge clk); #1;
        check(rd_data, 8'h00, "R1 rd after reset");
        check(clk_en, 1, "R1 first strobe");
        @(negedge clk); #1;
        check(clk_en, 1, "R2 div1 strobe");

        switch_to(3);

        // R5: unarmed select write
        wr_byte(8'h02);
        check(rd_data, 8'h03, "R5 unarmed write ignored");
        expect_steady(8, 2);

        // R3: non-exact arming
        wr_byte(8'h81);
        check(rd_data, 8'h03, "R3 0x81 does not arm");
        wr_byte(8'h80);
        check(rd_data, 8'h83, "R3 arm flag visible");
        // R7: malformed write while armed
        wr_byte(8'h85);
        check(rd_data, 8'h03, "R7 malformed write clears arm");

        // R6: reserved code
        wr_byte(8'h80);
        wr_byte(8'h0C);
        check(rd_data, 8'h03, "R6 reserved code ignored");

        // R4: late write
        wr_byte(8'h80);
        idle(3);
        check(rd_data, 8'h83, "R4 armed at fourth cycle");
        idle(1);
        check(rd_data, 8'h03, "R4 arm expired");
        wr_byte(8'h02);
        check(rd_data, 8'h03, "R4 late write ignored");

        // R4: write on last cycle of window
        wr_byte(8'h80);
        idle(3);
        wr_byte(8'h02);
        check(rd_data, 8'h02, "R4 R10 edge write accepted");
        model_code = 2;
        expect_steady(4, 3);

        switch_to(0);
        switch_to(8);
        switch_to(1);
        expect_steady(2, 3);
        while (exp_q.size() != 0) @(negedge clk);

        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        checks++; fails++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule